// File: doc/BRIEF.md
# Program/Erase Suspend-Resume Sequencer

This block sequences the self-timed program and erase operations of a serial flash device and lets them be paused and resumed. A command decoder hands it one decoded command at a time (page program, 4 KB / 32 KB / 64 KB block erase, chip erase, a protection change, or a read). It also receives single-cycle strobes for suspend, resume and a device soft reset. A down-counter loaded with a per-operation cycle count stands in for the busy time. The block drives a busy flag and two suspend status bits, and answers every command with a one-cycle accept or reject pulse.

While an erase is paused, the host may run one program cycle to an address outside the region being erased. That program cannot itself be paused. Once it finishes, the block returns to the paused erase. The remaining count of the paused operation is frozen across the pause, so an operation shows busy for exactly its configured number of cycles in total, however it is split. Array contents and the serial protocol are handled elsewhere.

Top module: `pe_suspend_seq`

## Requirements
- R1: After reset, busy, prog_susp, erase_susp, cmd_accept, cmd_reject and op_done are all low.
- R2: In idle, a command with cmd_op 1 (page program), 2 (4 KB erase), 3 (32 KB erase), 4 (64 KB erase) or 5 (chip erase) is accepted: cmd_accept pulses in the next cycle. Busy is then high for exactly T_PROG, T_ER4K, T_ER32K, T_ER64K or T_CHIP cycles. op_done pulses for one cycle as busy falls.
- R3: While an operation runs and is not suspended, every command with a nonzero cmd_op is rejected: cmd_reject pulses in the next cycle and the running operation keeps its timing.
- R4: A suspend strobe during a running operation drops busy in the next cycle. It sets prog_susp for a program, or erase_susp for any erase, and never both. A suspend strobe sampled in the operation's final busy cycle is ignored: the operation completes with op_done and no flag is set.
- R5: A suspend strobe while idle or already suspended changes nothing. A resume strobe while idle changes nothing.
- R6: A resume strobe while suspended raises busy in the next cycle and clears the suspend flag. The busy cycles before the suspend and after the resume add up to the operation's full duration.
- R7: While suspended, a protection command (cmd_op 6) is rejected and a read (cmd_op 7) is accepted.
- R8: While suspended, every erase command (cmd_op 2 to 5) is rejected. While a program is suspended, a further program command is also rejected.
- R9: While an erase is suspended, a program command is accepted only if its address lies outside the suspended erase region. That region is the aligned 4 KB, 32 KB or 64 KB block holding the erase address, or the whole array for chip erase. An accepted program runs busy for T_PROG cycles with erase_susp still high, pulses op_done, and returns to the suspended state with busy low.
- R10: While such a nested program runs, suspend and resume strobes are ignored and every command is rejected.
- R11: A dev_reset strobe returns the block to idle from any state and clears both suspend flags. A later resume strobe then does not raise busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A decoded command is presented this cycle |
| cmd_op | input | 3 | Command code (0 none, 1 program, 2/3/4 block erase 4/32/64 KB, 5 chip erase, 6 protection change, 7 read) |
| cmd_addr | input | ADDR_W | Byte address of the command |
| susp_req | input | 1 | Suspend strobe (chip select rose after a suspend opcode) |
| resume_req | input | 1 | Resume strobe |
| dev_reset | input | 1 | Soft device reset strobe |
| busy | output | 1 | A timed operation is in progress |
| prog_susp | output | 1 | A program operation is suspended |
| erase_susp | output | 1 | An erase operation is suspended |
| cmd_accept | output | 1 | Pulse: the previous cycle's command was allowed |
| cmd_reject | output | 1 | Pulse: the previous cycle's command was refused |
| op_done | output | 1 | Pulse: a timed operation finished |

## Verification
A corrupted remaining count shows up only as a total busy time that differs from the configured duration. It is therefore measured by summing busy cycles on both sides of a pause, not by sampling one instant. A wrong suspend kind or a stale erase region shows up at the first filtered command after the pause, one cycle after it is sampled, as an accept where a reject was due or the reverse. A state machine stuck in the nested program shows up as erase_susp with busy high past T_PROG cycles, or as a resume that does not raise busy one cycle later.

// File: rtl/pes_pkg.sv
package pes_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_PROG  = 3'd1,
    OP_ER4K  = 3'd2,
    OP_ER32K = 3'd3,
    OP_ER64K = 3'd4,
    OP_CHIP  = 3'd5,
    OP_PROT  = 3'd6,
    OP_READ  = 3'd7
  } pes_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_SUSP = 2'd2,
    ST_NEST = 2'd3
  } pes_state_e;

  typedef enum logic [1:0] {
    SPAN_4K  = 2'd0,
    SPAN_32K = 2'd1,
    SPAN_64K = 2'd2,
    SPAN_ALL = 2'd3
  } pes_span_e;

  function automatic logic op_is_timed(pes_op_e op);
    return (op == OP_PROG) || (op == OP_ER4K) || (op == OP_ER32K) ||
           (op == OP_ER64K) || (op == OP_CHIP);
  endfunction

  function automatic logic op_is_erase(pes_op_e op);
    return (op == OP_ER4K) || (op == OP_ER32K) || (op == OP_ER64K) || (op == OP_CHIP);
  endfunction

  function automatic pes_span_e op_span(pes_op_e op);
    case (op)
      OP_ER32K: return SPAN_32K;
      OP_ER64K: return SPAN_64K;
      OP_CHIP:  return SPAN_ALL;
      default:  return SPAN_4K;
    endcase
  endfunction

endpackage

// File: rtl/pes_countdown.sv
module pes_countdown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic             last
);

  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] rem_d;
  logic             rem_en;

  assign rem_en = load | step;

  always_comb begin
    rem_d = rem_q;
    if (load) begin
      rem_d = load_val;
    end else if (step && (rem_q != '0)) begin
      rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (rem_en) begin
      rem_q <= rem_d;
    end
  end

  assign last = (rem_q == {{(CNT_W-1){1'b0}}, 1'b1});

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0)); // R2

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |-> (rem_q != '0)); // R6

endmodule

// File: rtl/pes_cmd_filter.sv
module pes_cmd_filter
  import pes_pkg::*;
#(
  parameter int ADDR_W = 23
) (
  input  pes_state_e        state,
  input  logic              valid,
  input  pes_op_e           op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] region_base,
  input  pes_span_e         region_span,
  input  logic              erase_held,
  output logic              allow,
  output logic              refuse,
  output logic              start_main,
  output logic              start_nest
);

  localparam int SH_4K  = 12;
  localparam int SH_32K = 15;
  localparam int SH_64K = 16;

  logic [ADDR_W-1:0] region_mask;
  logic              in_region;

  always_comb begin
    case (region_span)
      SPAN_4K:  region_mask = {ADDR_W{1'b1}} << SH_4K;
      SPAN_32K: region_mask = {ADDR_W{1'b1}} << SH_32K;
      SPAN_64K: region_mask = {ADDR_W{1'b1}} << SH_64K;
      default:  region_mask = '0;
    endcase
  end

  assign in_region = (((addr ^ region_base) & region_mask) == '0);

  always_comb begin
    allow      = 1'b0;
    refuse     = 1'b0;
    start_main = 1'b0;
    start_nest = 1'b0;
    if (valid && (op != OP_NONE)) begin
      case (state)
        ST_IDLE: begin
          allow      = 1'b1;
          start_main = op_is_timed(op);
        end
        ST_SUSP: begin
          case (op)
            OP_READ: allow = 1'b1;
            OP_PROG: begin
              if (erase_held && !in_region) begin
                allow      = 1'b1;
                start_nest = 1'b1;
              end else begin
                refuse = 1'b1;
              end
            end
            default: refuse = 1'b1;
          endcase
        end
        default: refuse = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/pe_suspend_seq.sv
module pe_suspend_seq
  import pes_pkg::*;
#(
  parameter int ADDR_W  = 23,
  parameter int T_PROG  = 20,
  parameter int T_ER4K  = 40,
  parameter int T_ER32K = 60,
  parameter int T_ER64K = 80,
  parameter int T_CHIP  = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              susp_req,
  input  logic              resume_req,
  input  logic              dev_reset,
  output logic              busy,
  output logic              prog_susp,
  output logic              erase_susp,
  output logic              cmd_accept,
  output logic              cmd_reject,
  output logic              op_done
);

  localparam int T_MAX_A = (T_PROG > T_ER4K) ? T_PROG : T_ER4K;
  localparam int T_MAX_B = (T_ER32K > T_ER64K) ? T_ER32K : T_ER64K;
  localparam int T_MAX_C = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
  localparam int T_MAX   = (T_MAX_C > T_CHIP) ? T_MAX_C : T_CHIP;
  localparam int CNT_W   = $clog2(T_MAX + 1);

  pes_state_e        state_q, state_d;
  logic              psus_q, psus_d;
  logic              esus_q, esus_d;
  logic              acc_q, acc_d;
  logic              rej_q, rej_d;
  logic              done_q, done_d;
  logic              cfg_en;
  logic              erase_q;
  pes_span_e         span_q;
  logic [ADDR_W-1:0] base_q;

  pes_op_e           op_in;
  logic              f_valid;
  logic              f_acc, f_rej;
  logic              start_main, start_nest;
  logic              main_last, nest_last;
  logic [CNT_W-1:0]  main_len;

  assign op_in   = pes_op_e'(cmd_op);
  assign f_valid = cmd_valid & ~dev_reset;

  always_comb begin
    case (op_in)
      OP_PROG:  main_len = CNT_W'(T_PROG);
      OP_ER4K:  main_len = CNT_W'(T_ER4K);
      OP_ER32K: main_len = CNT_W'(T_ER32K);
      OP_ER64K: main_len = CNT_W'(T_ER64K);
      OP_CHIP:  main_len = CNT_W'(T_CHIP);
      default:  main_len = CNT_W'(1);
    endcase
  end

  pes_cmd_filter #(
    .ADDR_W (ADDR_W)
  ) u_filter (
    .state       (state_q),
    .valid       (f_valid),
    .op          (op_in),
    .addr        (cmd_addr),
    .region_base (base_q),
    .region_span (span_q),
    .erase_held  (esus_q),
    .allow       (f_acc),
    .refuse      (f_rej),
    .start_main  (start_main),
    .start_nest  (start_nest)
  );

  pes_countdown #(
    .CNT_W (CNT_W)
  ) u_main_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_main),
    .load_val (main_len),
    .step     (state_q == ST_RUN),
    .last     (main_last)
  );

  pes_countdown #(
    .CNT_W (CNT_W)
  ) u_nest_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_nest),
    .load_val (CNT_W'(T_PROG)),
    .step     (state_q == ST_NEST),
    .last     (nest_last)
  );

  always_comb begin
    state_d = state_q;
    psus_d  = psus_q;
    esus_d  = esus_q;
    acc_d   = f_acc;
    rej_d   = f_rej;
    done_d  = 1'b0;
    cfg_en  = 1'b0;
    if (dev_reset) begin
      state_d = ST_IDLE;
      psus_d  = 1'b0;
      esus_d  = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_main) begin
            state_d = ST_RUN;
            cfg_en  = 1'b1;
          end
        end
        ST_RUN: begin
          if (main_last) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else if (susp_req) begin
            state_d = ST_SUSP;
            if (erase_q) esus_d = 1'b1;
            else         psus_d = 1'b1;
          end
        end
        ST_SUSP: begin
          if (start_nest) begin
            state_d = ST_NEST;
          end else if (resume_req) begin
            state_d = ST_RUN;
            psus_d  = 1'b0;
            esus_d  = 1'b0;
          end
        end
        ST_NEST: begin
          if (nest_last) begin
            state_d = ST_SUSP;
            done_d  = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      psus_q  <= 1'b0;
      esus_q  <= 1'b0;
      acc_q   <= 1'b0;
      rej_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      psus_q  <= psus_d;
      esus_q  <= esus_d;
      acc_q   <= acc_d;
      rej_q   <= rej_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_q <= 1'b0;
      span_q  <= SPAN_4K;
      base_q  <= '0;
    end else if (cfg_en) begin
      erase_q <= op_is_erase(op_in);
      span_q  <= op_span(op_in);
      base_q  <= cmd_addr;
    end
  end

  assign busy       = (state_q == ST_RUN) || (state_q == ST_NEST);
  assign prog_susp  = psus_q;
  assign erase_susp = esus_q;
  assign cmd_accept = acc_q;
  assign cmd_reject = rej_q;
  assign op_done    = done_q;

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> $past(busy)); // R2

  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && (cmd_op != 3'd0) && !dev_reset) |=> cmd_reject); // R3

  AST_ONE_SUSP_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_susp && erase_susp)); // R4

  AST_IDLE_SUSP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !prog_susp && !erase_susp && susp_req && !dev_reset)
      |=> (!prog_susp && !erase_susp)); // R5

  AST_RESUME_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SUSP) && resume_req && !start_nest && !dev_reset)
      |=> (busy && !prog_susp && !erase_susp)); // R6

  AST_PROT_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    ((prog_susp || erase_susp) && !busy && cmd_valid && (cmd_op == 3'd6) && !dev_reset)
      |=> cmd_reject); // R7

  AST_PROG_SUSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    prog_susp |-> !busy); // R8

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset |=> (!busy && !prog_susp && !erase_susp)); // R11

endmodule

// File: tb/pe_suspend_seq_tb.sv
module pe_suspend_seq_tb;

  localparam int AW      = 23;
  localparam int D_PROG  = 20;
  localparam int D_ER4K  = 40;
  localparam int D_ER32K = 60;
  localparam int D_ER64K = 80;
  localparam int D_CHIP  = 100;

  logic          clk;
  logic          rst_n;
  logic          cmd_valid;
  logic [2:0]    cmd_op;
  logic [AW-1:0] cmd_addr;
  logic          susp_req;
  logic          resume_req;
  logic          dev_reset;
  logic          busy;
  logic          prog_susp;
  logic          erase_susp;
  logic          cmd_accept;
  logic          cmd_reject;
  logic          op_done;

  int n_tests;
  int n_fail;
  int busy_cnt;

  pe_suspend_seq #(
    .ADDR_W  (AW),
    .T_PROG  (D_PROG),
    .T_ER4K  (D_ER4K),
    .T_ER32K (D_ER32K),
    .T_ER64K (D_ER64K),
    .T_CHIP  (D_CHIP)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .susp_req   (susp_req),
    .resume_req (resume_req),
    .dev_reset  (dev_reset),
    .busy       (busy),
    .prog_susp  (prog_susp),
    .erase_susp (erase_susp),
    .cmd_accept (cmd_accept),
    .cmd_reject (cmd_reject),
    .op_done    (op_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    #2;
    if (busy === 1'b1) busy_cnt++;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [AW-1:0] a,
                      output logic acc, output logic rej);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_addr  = a;
    @(posedge clk);
    #1;
    acc = cmd_accept;
    rej = cmd_reject;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 3'd0;
  endtask

  task automatic pulse_susp();
    susp_req = 1'b1;
    @(negedge clk);
    susp_req = 1'b0;
  endtask

  task automatic pulse_resume();
    resume_req = 1'b1;
    @(negedge clk);
    resume_req = 1'b0;
  endtask

  task automatic pulse_reset();
    dev_reset = 1'b1;
    @(negedge clk);
    dev_reset = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    while (busy) @(negedge clk);
    check(req, "op_done as busy falls", int'(op_done), 1);
  endtask

  task automatic t_reset_state();
    check("R1", "busy", int'(busy), 0);
    check("R1", "prog_susp", int'(prog_susp), 0);
    check("R1", "erase_susp", int'(erase_susp), 0);
    check("R1", "accept/reject/done", int'({cmd_accept, cmd_reject, op_done}), 0);
  endtask

  task automatic t_durations();
    logic a, r;
    int c0;
    int exp_len [5] = '{D_PROG, D_ER4K, D_ER32K, D_ER64K, D_CHIP};
    for (int i = 0; i < 5; i++) begin
      c0 = busy_cnt;
      send(3'(i + 1), 23'h040000, a, r);
      check("R2", "accept of timed op", int'(a), 1);
      wait_idle("R2");
      check("R2", "busy cycles", busy_cnt - c0, exp_len[i]);
    end
  endtask

  task automatic t_busy_refuses();
    logic a, r;
    int c0;
    c0 = busy_cnt;
    send(3'd1, 23'h000100, a, r);
    send(3'd7, 23'h000000, a, r);
    check("R3", "read while running rejected", int'(r), 1);
    send(3'd2, 23'h000000, a, r);
    check("R3", "erase while running rejected", int'(r), 1);
    wait_idle("R3");
    check("R3", "running op timing kept", busy_cnt - c0, D_PROG);
  endtask

  task automatic t_idle_strobes();
    pulse_susp();
    check("R5", "idle suspend flags", int'({prog_susp, erase_susp}), 0);
    check("R5", "idle suspend busy", int'(busy), 0);
    pulse_resume();
    check("R5", "idle resume busy", int'(busy), 0);
  endtask

  task automatic t_prog_suspend();
    logic a, r;
    int c0, pre, c1;
    c0 = busy_cnt;
    send(3'd1, 23'h000200, a, r);
    repeat (5) @(negedge clk);
    pulse_susp();
    check("R4", "busy after suspend", int'(busy), 0);
    check("R4", "prog_susp set", int'(prog_susp), 1);
    check("R4", "erase_susp clear", int'(erase_susp), 0);
    pre = busy_cnt - c0;
    pulse_susp();
    check("R5", "second suspend no change", int'({busy, prog_susp, erase_susp}), 3'b010);
    repeat (8) @(negedge clk);
    check("R6", "no busy while suspended", busy_cnt - c0, pre);
    send(3'd6, 23'h000000, a, r);
    check("R7", "protect rejected", int'(r), 1);
    send(3'd7, 23'h000000, a, r);
    check("R7", "read accepted", int'(a), 1);
    send(3'd1, 23'h300000, a, r);
    check("R8", "program during program suspend", int'(r), 1);
    send(3'd4, 23'h300000, a, r);
    check("R8", "erase during suspend", int'(r), 1);
    check("R8", "still suspended", int'({busy, prog_susp}), 2'b01);
    c1 = busy_cnt;
    pulse_resume();
    check("R6", "busy after resume", int'(busy), 1);
    check("R6", "flags after resume", int'({prog_susp, erase_susp}), 0);
    wait_idle("R6");
    check("R6", "total program busy", pre + (busy_cnt - c1), D_PROG);
  endtask

  task automatic t_last_cycle_suspend();
    logic a, r;
    send(3'd1, 23'h000000, a, r);
    repeat (D_PROG - 1) @(negedge clk);
    pulse_susp();
    check("R4", "last-cycle suspend: busy", int'(busy), 0);
    check("R4", "last-cycle suspend: done", int'(op_done), 1);
    check("R4", "last-cycle suspend: flags", int'({prog_susp, erase_susp}), 0);
  endtask

  task automatic t_erase_nest();
    logic a, r;
    int c0, pre, c1, c2;
    c0 = busy_cnt;
    send(3'd2, 23'h001000, a, r);
    repeat (3) @(negedge clk);
    pulse_susp();
    check("R4", "erase_susp set", int'({busy, prog_susp, erase_susp}), 3'b001);
    pre = busy_cnt - c0;
    send(3'd1, 23'h001FFF, a, r);
    check("R9", "program inside 4K region rejected", int'(r), 1);
    send(3'd3, 23'h100000, a, r);
    check("R8", "erase during erase suspend", int'(r), 1);
    c1 = busy_cnt;
    send(3'd1, 23'h002000, a, r);
    check("R9", "program outside region accepted", int'(a), 1);
    check("R9", "nested busy", int'(busy), 1);
    pulse_susp();
    check("R10", "suspend during nested", int'({busy, prog_susp, erase_susp}), 3'b101);
    pulse_resume();
    check("R10", "resume during nested", int'({busy, prog_susp, erase_susp}), 3'b101);
    send(3'd7, 23'h000000, a, r);
    check("R10", "read during nested rejected", int'(r), 1);
    wait_idle("R9");
    check("R9", "nested program length", busy_cnt - c1, D_PROG);
    check("R9", "erase still suspended", int'(erase_susp), 1);
    c2 = busy_cnt;
    pulse_resume();
    check("R6", "erase resumes", int'({busy, erase_susp}), 2'b10);
    wait_idle("R6");
    check("R6", "total erase busy", pre + (busy_cnt - c2), D_ER4K);
  endtask

  task automatic t_span64();
    logic a, r;
    send(3'd4, 23'h010000, a, r);
    repeat (4) @(negedge clk);
    pulse_susp();
    send(3'd1, 23'h01F000, a, r);
    check("R9", "program inside 64K region rejected", int'(r), 1);
    send(3'd1, 23'h020000, a, r);
    check("R9", "program outside 64K region accepted", int'(a), 1);
    wait_idle("R9");
    pulse_resume();
    wait_idle("R6");
  endtask

  task automatic t_chip_reset();
    logic a, r;
    send(3'd5, 23'h000000, a, r);
    repeat (4) @(negedge clk);
    pulse_susp();
    send(3'd1, 23'h7FFF00, a, r);
    check("R9", "program during chip-erase suspend rejected", int'(r), 1);
    pulse_reset();
    check("R11", "state after soft reset", int'({busy, prog_susp, erase_susp}), 0);
    pulse_resume();
    check("R11", "resume after soft reset", int'(busy), 0);
    send(3'd1, 23'h000000, a, r);
    check("R11", "idle again after soft reset", int'(a), 1);
    wait_idle("R11");
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests    = 0;
    n_fail     = 0;
    busy_cnt   = 0;
    rst_n      = 1'b0;
    cmd_valid  = 1'b0;
    cmd_op     = 3'd0;
    cmd_addr   = '0;
    susp_req   = 1'b0;
    resume_req = 1'b0;
    dev_reset  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_durations();
    t_busy_refuses();
    t_idle_strobes();
    t_prog_suspend();
    t_last_cycle_suspend();
    t_erase_nest();
    t_span64();
    t_chip_reset();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule